// File: doc/BRIEF.md
# Shift Unit with Status Flags

This block shifts a data word left or right, logically or arithmetically, and keeps a small register of status flags that reports carry, overflow, sign, zero, parity and an auxiliary carry. Each operation is requested by a one-cycle valid strobe that carries the operand, a shift count and an operation code. The shifted word and the updated flags are registered on that clock edge and held until the next strobe.

The flag rules follow the usual general-purpose processor convention. A zero count leaves the flags alone. Overflow is written only by one-bit shifts. Carry holds the last bit that left the word. Flags that the convention leaves open get a fixed value: the auxiliary carry is cleared, and carry is forced to zero for logical shifts whose count reaches the word width. The count is masked to a fixed number of low bits before use. With a 32-bit word this makes oversize counts wrap. With a narrower word, counts past the width remain possible.

Top module: `shift_flag_unit`

## Requirements
- R1: While rst_ni is low, result_o and flags_o are zero. The flags_o bit positions are [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign, [5] overflow.
- R2: Only the low CNT_W (default 5) bits of count_i are used, so with the default parameters a raw count of 33 acts as 1.
- R3: op_i selects the operation: 00 logical left, 01 logical right, 10 arithmetic right (sign fill), 11 logical right. result_o is the operand shifted by the masked count.
- R4: On a nonzero count below the width, carry is the last bit shifted out.
- R5: When the masked count is at least WIDTH, logical shifts give carry 0 and result 0. The arithmetic shift gives a result of all sign bits and a carry equal to the sign bit.
- R6: On a count of exactly 1, overflow takes a value that depends on the shift. For a left shift it is the new top bit XOR carry. For a logical right shift it is the original top bit. For an arithmetic right shift it is 0.
- R7: On a count of 2 or more, overflow keeps its previous value.
- R8: On any nonzero count, sign is the top result bit and zero is set when the result is 0. Parity is set when result bits [7:0] hold an even number of ones.
- R9: On any nonzero count, the auxiliary flag is cleared.
- R10: On a zero count, no flag changes and result_o takes the unshifted operand.
- R11: Without valid_i, result_o and flags_o hold their values.
- R12: An arithmetic right shift by 1 of all ones gives all ones, with sign 1, zero 0 and carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select |
| operand_i | input | WIDTH | Data to shift |
| count_i | input | CNT_IN_W | Raw shift count |
| result_o | output | WIDTH | Registered shifted data |
| flags_o | output | 6 | Registered status flags |

## Verification
The main collision is between updating the result and holding the flags. A zero-count strobe follows a strobe that left distinctive flags, and the bench checks that result_o changes to the new operand while every flag bit keeps its old value. A second collision arises when an oversize logical shift forces carry to zero while overflow must keep a value set by an earlier one-bit shift. An exhaustive sweep of an 8-bit instance over every operand, masked count and operation provokes this case, and a bit-by-bit reference model in the bench judges each result.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_ARITH = 2'b10,
    SH_ALT   = 2'b11
  } shift_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flag_t;

endpackage

// File: rtl/shift_core.sv
module shift_core
  import shift_flag_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 5
) (
  input  shift_op_e          op_i,
  input  logic [WIDTH-1:0]   data_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [WIDTH-1:0]   res_o,
  output logic               cout_o
);
  localparam int CNT_RANGE = 1 << CNT_W;

  logic [WIDTH:0]        left_ext, right_ext;
  logic signed [WIDTH:0] arith_ext;
  logic                  oversize;

  generate
    if (CNT_RANGE > WIDTH) begin : g_over
      assign oversize = (int'(cnt_i) >= WIDTH);
    end else begin : g_no_over
      assign oversize = 1'b0;
    end
  endgenerate

  always_comb begin
    left_ext  = {1'b0, data_i} << cnt_i;
    right_ext = {data_i, 1'b0} >> cnt_i;
    arith_ext = $signed({data_i, 1'b0}) >>> cnt_i;
    case (op_i)
      SH_LEFT: begin
        res_o  = left_ext[WIDTH-1:0];
        cout_o = oversize ? 1'b0 : left_ext[WIDTH];
      end
      SH_ARITH: begin
        res_o  = arith_ext[WIDTH:1];
        cout_o = arith_ext[0];
      end
      default: begin
        res_o  = right_ext[WIDTH:1];
        cout_o = oversize ? 1'b0 : right_ext[0];
      end
    endcase
  end

  always_comb begin
    if (op_i == SH_ARITH) begin
      p_sar_sign_r3: assert (res_o[WIDTH-1] == data_i[WIDTH-1]);
    end
  end

endmodule

// File: rtl/shift_flag_next.sv
module shift_flag_next
  import shift_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  shift_op_e        op_i,
  input  logic             src_msb_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             cnt_zero_i,
  input  logic             cnt_one_i,
  input  flag_t            flags_q_i,
  output flag_t            flags_d_o
);
  logic ovf_one;

  always_comb begin
    case (op_i)
      SH_LEFT:  ovf_one = res_i[WIDTH-1] ^ cout_i;
      SH_ARITH: ovf_one = 1'b0;
      default:  ovf_one = src_msb_i;
    endcase
  end

  always_comb begin
    if (cnt_zero_i) begin
      flags_d_o = flags_q_i;
    end else begin
      flags_d_o.cry = cout_i;
      flags_d_o.par = ~^res_i[7:0];
      flags_d_o.aux = 1'b0;
      flags_d_o.zro = ~|res_i;
      flags_d_o.sgn = res_i[WIDTH-1];
      flags_d_o.ovf = cnt_one_i ? ovf_one : flags_q_i.ovf;
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          op_i,
  input  logic [WIDTH-1:0]    operand_i,
  input  logic [CNT_IN_W-1:0] count_i,
  output logic [WIDTH-1:0]    result_o,
  output logic [5:0]          flags_o
);
  shift_op_e        op;
  logic [CNT_W-1:0] cnt_m;
  logic [WIDTH-1:0] res_d, res_q;
  logic             cout;
  flag_t            flags_d, flags_q;

  assign op    = shift_op_e'(op_i);
  assign cnt_m = count_i[CNT_W-1:0];

  shift_core #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_core (
    .op_i   (op),
    .data_i (operand_i),
    .cnt_i  (cnt_m),
    .res_o  (res_d),
    .cout_o (cout)
  );

  shift_flag_next #(.WIDTH(WIDTH)) u_flags (
    .op_i       (op),
    .src_msb_i  (operand_i[WIDTH-1]),
    .res_i      (res_d),
    .cout_i     (cout),
    .cnt_zero_i (cnt_m == '0),
    .cnt_one_i  (cnt_m == CNT_W'(1)),
    .flags_q_i  (flags_q),
    .flags_d_o  (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (valid_i) begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign result_o = res_q;
  assign flags_o  = flags_q;

  p_zero_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m == '0 |=> $stable(flags_o));
  p_zero_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m == '0 |=> result_o == $past(operand_i));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o));
  p_ovf_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m > CNT_W'(1) |=> flags_o[5] == $past(flags_o[5]));
  p_aux_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m != '0 |=> !flags_o[2]);
  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m != '0 |=> flags_o[3] == (result_o == '0));
  p_sar_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_m == CNT_W'(1) && op_i == 2'b10 |=> !flags_o[5]);

endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        va = 0, vb = 0;
  logic [1:0]  opa = 0, opb = 0;
  logic [31:0] da = 0;
  logic [7:0]  db = 0, ca = 0, cb = 0;
  logic [31:0] ra;
  logic [7:0]  rb;
  logic [5:0]  fa, fb;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [5:0]  exp_fa = 0, exp_fb = 0;

  shift_flag_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(va), .op_i(opa),
    .operand_i(da), .count_i(ca), .result_o(ra), .flags_o(fa));

  shift_flag_unit #(.WIDTH(8)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vb), .op_i(opb),
    .operand_i(db), .count_i(cb), .result_o(rb), .flags_o(fb));

  // bit-serial reference
  function automatic void model(input int w, input logic [1:0] op, input logic [31:0] a_in,
                                input logic [7:0] raw, input logic [5:0] fo,
                                output logic [31:0] r, output logic [5:0] f);
    logic [31:0] mask, a;
    logic cf, msb0;
    int c;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    a = a_in & mask;
    c = int'(raw & 8'd31);
    f = fo;
    if (c == 0) begin
      r = a;
      return;
    end
    msb0 = a[w-1];
    cf = 1'b0;
    for (int i = 0; i < c; i++) begin
      if (op == 2'b00) begin
        cf = a[w-1];
        a = (a << 1) & mask;
      end else if (op == 2'b10) begin
        logic s;
        s = a[w-1];
        cf = a[0];
        a = (a >> 1) | ({31'd0, s} << (w-1));
      end else begin
        cf = a[0];
        a = a >> 1;
      end
    end
    if (op != 2'b10 && c >= w) cf = 1'b0;
    r = a;
    f[0] = cf;
    f[1] = ~^a[7:0];
    f[2] = 1'b0;
    f[3] = (a == 0);
    f[4] = a[w-1];
    if (c == 1) begin
      if (op == 2'b00) f[5] = a[w-1] ^ cf;
      else if (op == 2'b10) f[5] = 1'b0;
      else f[5] = msb0;
    end
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
               tag, act[37:6], act[5:0], exp[37:6], exp[5:0]);
    end
  endtask

  task automatic step(input bit sel, input logic [1:0] op, input logic [31:0] val, input logic [7:0] cnt);
    logic [31:0] r;
    logic [5:0] f;
    string tag;
    int w, c;
    w = sel ? 8 : 32;
    c = int'(cnt & 8'd31);
    model(w, op, val, cnt, sel ? exp_fb : exp_fa, r, f);
    if (!sel && cnt > 8'd31) tag = "R2";
    else if (c == 0) tag = "R10";
    else if (c == 1 && op == 2'b10 && r == ((w == 32) ? 32'hFFFF_FFFF : 32'hFF)) tag = "R12";
    else if (c >= w) tag = "R5";
    else if (c == 1) tag = "R6";
    else tag = "R3 R4 R7 R8 R9";
    @(negedge clk);
    if (sel) begin vb = 1; opb = op; db = val[7:0]; cb = cnt; end
    else begin va = 1; opa = op; da = val; ca = cnt; end
    @(negedge clk);
    va = 0; vb = 0;
    if (sel) begin
      exp_fb = f;
      check(tag, {24'd0, rb, fb}, {r, f});
    end else begin
      exp_fa = f;
      check(tag, {ra, fa}, {r, f});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [8];
    logic [7:0]  cnts [10];
    logic [31:0] keep_r;
    logic [5:0]  keep_f;
    pats = '{32'h0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF,
             32'h7FFF_FFFF, 32'hA5A5_A5A5, 32'h1234_5678, 32'hC000_0001};
    cnts = '{8'd0, 8'd1, 8'd2, 8'd5, 8'd16, 8'd31, 8'd32, 8'd33, 8'd63, 8'd255};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {ra, fa}, 38'd0);
    check("R1", {24'd0, rb, fb}, 38'd0);
    rst_n = 1;
    @(negedge clk);

    // R12 sign-fill shift by one
    step(0, 2'b10, 32'hFFFF_FFFF, 8'd1);
    check("R12", {ra, fa[4], fa[3], fa[0]}, {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1});

    // R7: set overflow, then multi-bit shift keeps it
    step(0, 2'b00, 32'h4000_0000, 8'd1);
    check("R6", {32'd0, fa[5]}, {32'd0, 1'b1});
    step(0, 2'b01, 32'h0000_00F0, 8'd3);
    check("R7", {32'd0, fa[5]}, {32'd0, 1'b1});

    // R10 zero count after flag-setting op
    step(0, 2'b00, 32'h8000_0000, 8'd1);
    keep_f = fa;
    step(0, 2'b01, 32'h0000_0000, 8'd32);
    check("R10", {ra, fa}, {32'd0, keep_f});

    // R11 idle hold
    keep_r = ra;
    keep_f = fa;
    @(negedge clk);
    da = 32'hDEAD_BEEF; ca = 8'd3; opa = 2'b00;
    repeat (2) @(negedge clk);
    check("R11", {ra, fa}, {keep_r, keep_f});

    // 32-bit patterns
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 10; k++)
          step(0, 2'(o), pats[p], cnts[k]);

    // exhaustive narrow sweep, covers oversize counts (R5)
    for (int o = 0; o < 4; o++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 32; c++)
          step(1, 2'(o), 32'(v), 8'(c));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule